// File: doc/BRIEF.md
# Five-Port Unicast Mesh Node Switch

This block is the data crossbar inside a single node of a circuit-switched mesh. It has five ports: Memory (index 0), North (1), East (2), West (3) and South (4). Each port has a data input with a valid bit and a registered data output with a valid bit. A local decoder supplies a 5-bit route code that names one source port and one destination port. At most one unicast connection passes through the node at any time. Every output that is not the destination of the active route drives zero.

The route code is captured into a select register when `route_load` is high. The register keeps its value until it is loaded again or reset. The West port also has a single-word park buffer. When the node is still carrying an earlier path and a word for a second path arrives on West, the decoder raises `park_west`. The word is then held instead of forwarded. When the earlier path is torn down, the decoder raises `release_hold`. For one cycle the parked word then takes the place of the West input, and it leaves through whatever output the current route sends West to.

The park buffer is a three-state machine. EMPTY goes to PARKED when a park request meets a valid West word. PARKED goes to SEND when a release arrives. SEND returns to EMPTY after exactly one cycle and clears the buffer. Every other input combination leaves the state unchanged.

Top module: `mesh_switch5`

## Requirements
- R1: For codes 1 to 20, let k = code-1. The source port is k/4, in port-index order (Memory 0, North 1, East 2, West 3, South 4). The destination is entry k%4 of the other four ports, listed in ascending index order. Examples: code 7 routes North to West, code 14 routes West to North, code 20 routes South to West.
- R2: Code 0 and codes 21 to 31 are idle. Every output valid bit and every output data bit is zero.
- R3: At most one output valid bit is set in any cycle. Every port other than the active destination outputs zero valid and zero data.
- R4: The destination output's valid bit and data word equal the source input's valid bit and data word one clock earlier.
- R5: A code loaded at one clock edge steers the outputs from the next edge on. While `route_load` is low, changes on `route_code` have no effect.
- R6: An active-low reset acts asynchronously. It zeroes all outputs, makes the route idle and empties the park buffer, so a later release forwards nothing.
- R7: In EMPTY, `park_west` high with West valid captures the West word. That word is not forwarded in that cycle: an output routed from West shows valid 0.
- R8: In PARKED, the buffered word is kept. A West word arriving with `park_west` high is dropped. A West word arriving with `park_west` low passes through the route as usual.
- R9: Release while PARKED moves to SEND. At the following edge, the parked word, marked valid, replaces the West input (the live West input is ignored). The state then returns to EMPTY and the buffer clears.
- R10: `release_hold` has no effect while the buffer is EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_code | input | 5 | Unicast route code from the node decoder |
| route_load | input | 1 | Load `route_code` into the select register |
| park_west | input | 1 | Park the arriving West word instead of forwarding it |
| release_hold | input | 1 | Earlier path released; send the parked word |
| in_valid | input | 5 | Per-port input valid, bit index = port index |
| in_data | input | 5*DATA_W | Per-port input words, port p at bits p*DATA_W upward |
| out_valid | output | 5 | Per-port registered output valid |
| out_data | output | 5*DATA_W | Per-port registered output words |

## Verification
The bench builds the switch with its default 16-bit word. Every port is given a distinct input word, so a word delivered to the wrong port or taken from the wrong source shows up as a data mismatch and not only as a valid mismatch. All twenty codes and several idle codes are swept. The park, pass-through, drop and release sequence is driven on a West-sourced route, and an asynchronous reset is applied while a word is parked. A long run of random codes, loads, park and release pulses and input patterns then compares every cycle against the behavioural model.

// File: rtl/msw_pkg.sv
package msw_pkg;

    localparam int NPORT  = 5;
    localparam int PW     = 3;
    localparam int CODE_W = 5;
    localparam int NCODE  = NPORT * (NPORT - 1);

    typedef enum logic [PW-1:0] {
        P_MEM   = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_WEST  = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        H_EMPTY  = 2'd0,
        H_PARKED = 2'd1,
        H_SEND   = 2'd2
    } hold_e;

    typedef struct packed {
        logic  act;
        port_e src;
        port_e dst;
    } route_t;

    // Source group is code-1 divided by the fan-out; destination walks the
    // remaining ports in ascending index order.
    function automatic route_t decode_code(input logic [CODE_W-1:0] code);
        route_t r;
        int k;
        int g;
        int i;
        r.act = 1'b0;
        r.src = P_MEM;
        r.dst = P_MEM;
        k = int'(code) - 1;
        g = k / (NPORT - 1);
        i = k % (NPORT - 1);
        if (k >= 0 && k < NCODE) begin
            r.act = 1'b1;
            r.src = port_e'(g[PW-1:0]);
            r.dst = (i < g) ? port_e'(i[PW-1:0]) : port_e'(i[PW-1:0] + 3'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/msw_route_reg.sv
module msw_route_reg
    import msw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output route_t            rt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_q.act <= 1'b0;
            rt_q.src <= P_MEM;
            rt_q.dst <= P_MEM;
        end else if (load) begin
            rt_q <= decode_code(code);
        end
    end

    p_route_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rt_q));

endmodule

// File: rtl/msw_west_hold.sv
module msw_west_hold
    import msw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park,
    input  logic              rel,
    input  logic              w_vld,
    input  logic [DATA_W-1:0] w_data,
    output logic              eff_vld,
    output logic [DATA_W-1:0] eff_data
);

    hold_e             st_q, st_d;
    logic              cap;
    logic [DATA_W-1:0] buf_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= H_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        cap  = 1'b0;
        unique case (st_q)
            H_EMPTY: begin
                if (park && w_vld) begin
                    st_d = H_PARKED;
                    cap  = 1'b1;
                end
            end
            H_PARKED: begin
                if (rel) st_d = H_SEND;
            end
            H_SEND:  st_d = H_EMPTY;
            default: st_d = H_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              buf_q <= '0;
        else if (cap)            buf_q <= w_data;
        else if (st_q == H_SEND) buf_q <= '0;
    end

    // outputs: effective West source seen by the output cells
    always_comb begin
        eff_vld  = 1'b0;
        eff_data = '0;
        unique case (st_q)
            H_SEND: begin
                eff_vld  = 1'b1;
                eff_data = buf_q;
            end
            H_EMPTY, H_PARKED: begin
                if (!(park && w_vld)) begin
                    eff_vld  = w_vld;
                    eff_data = w_data;
                end
            end
            default: ;
        endcase
    end

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_EMPTY && park && w_vld) |=>
            (st_q == H_PARKED && buf_q == $past(w_data)));

    p_buf_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_PARKED) |=> $stable(buf_q));

    p_send_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_SEND) |=> (st_q == H_EMPTY && buf_q == '0));

    p_empty_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_EMPTY && !(park && w_vld)) |=> (st_q == H_EMPTY));

endmodule

// File: rtl/msw_out_cell.sv
module msw_out_cell
    import msw_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter port_e PORT   = P_MEM
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  route_t                        rt,
    input  logic [NPORT-1:0]              src_vld,
    input  logic [NPORT-1:0][DATA_W-1:0]  src_data,
    output logic                          o_vld,
    output logic [DATA_W-1:0]             o_data
);

    logic hit;
    assign hit = rt.act && (rt.dst == PORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_data <= '0;
        end else if (hit) begin
            o_vld  <= src_vld[rt.src];
            o_data <= src_data[rt.src];
        end else begin
            o_vld  <= 1'b0;
            o_data <= '0;
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rt.act |=> (!o_vld && o_data == '0));

    p_not_dest_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !o_vld);

    p_follow_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (o_vld == $past(src_vld[rt.src])));

endmodule

// File: rtl/mesh_switch5.sv
module mesh_switch5
    import msw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [4:0]                route_code,
    input  logic                      route_load,
    input  logic                      park_west,
    input  logic                      release_hold,
    input  logic [4:0]                in_valid,
    input  logic [5*DATA_W-1:0]       in_data,
    output logic [4:0]                out_valid,
    output logic [5*DATA_W-1:0]       out_data
);

    route_t                       rt_q;
    logic                         west_vld;
    logic [DATA_W-1:0]            west_data;
    logic [NPORT-1:0]             src_vld;
    logic [NPORT-1:0][DATA_W-1:0] src_data;

    msw_route_reg u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (route_load),
        .code  (route_code),
        .rt_q  (rt_q)
    );

    msw_west_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .park     (park_west),
        .rel      (release_hold),
        .w_vld    (in_valid[P_WEST]),
        .w_data   (in_data[int'(P_WEST)*DATA_W +: DATA_W]),
        .eff_vld  (west_vld),
        .eff_data (west_data)
    );

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            src_vld[p]  = in_valid[p];
            src_data[p] = in_data[p*DATA_W +: DATA_W];
        end
        src_vld[P_WEST]  = west_vld;
        src_data[P_WEST] = west_data;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_cell
        msw_out_cell #(.DATA_W(DATA_W), .PORT(port_e'(g))) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .rt       (rt_q),
            .src_vld  (src_vld),
            .src_data (src_data),
            .o_vld    (out_valid[g]),
            .o_data   (out_data[g*DATA_W +: DATA_W])
        );
    end

    p_unicast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) <= 1);

endmodule

// File: tb/test_mesh_switch5.sv
module test_mesh_switch5;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4:0]     route_code = '0;
    logic           route_load = 1'b0;
    logic           park_west = 1'b0;
    logic           release_hold = 1'b0;
    logic [4:0]     in_valid = '0;
    logic [5*W-1:0] in_data = '0;
    logic [4:0]     out_valid;
    logic [5*W-1:0] out_data;

    int    nchk = 0;
    int    nbad = 0;
    bit    done = 1'b0;
    string cur_req = "R6";

    // reference model state
    int             m_act, m_src, m_dst, m_hst;
    logic [W-1:0]   m_buf;
    logic [4:0]     e_vld;
    logic [5*W-1:0] e_dat;
    logic           wv;
    logic [W-1:0]   wd;

    always #4 clk = ~clk;

    mesh_switch5 #(.DATA_W(W)) i_mesh_switch5 (
        .clk(clk), .rst_n(rst_n), .route_code(route_code), .route_load(route_load),
        .park_west(park_west), .release_hold(release_hold), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic bdecode(input int c, output int a, output int s, output int d);
        int n;
        a = 0; s = 0; d = 0;
        if (c >= 1 && c <= 20) begin
            a = 1;
            s = (c - 1) / 4;
            n = (c - 1) % 4;
            for (int p = 0; p < 5; p++) begin
                if (p != s) begin
                    if (n == 0) d = p;
                    n--;
                end
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_src = 0; m_dst = 0; m_hst = 0;
            m_buf = '0; e_vld = '0; e_dat = '0;
        end else begin
            wv = in_valid[3];
            wd = in_data[3*W +: W];
            if (m_hst == 2) begin
                wv = 1'b1; wd = m_buf;
            end else if (park_west && in_valid[3]) begin
                wv = 1'b0; wd = '0;
            end
            e_vld = '0;
            e_dat = '0;
            if (m_act != 0) begin
                if (m_src == 3) begin
                    e_vld[m_dst] = wv;
                    e_dat[m_dst*W +: W] = wd;
                end else begin
                    e_vld[m_dst] = in_valid[m_src];
                    e_dat[m_dst*W +: W] = in_data[m_src*W +: W];
                end
            end
            case (m_hst)
                0: if (park_west && in_valid[3]) begin m_hst = 1; m_buf = in_data[3*W +: W]; end
                1: if (release_hold) m_hst = 2;
                default: begin m_hst = 0; m_buf = '0; end
            endcase
            if (route_load) bdecode(int'(route_code), m_act, m_src, m_dst);
        end
    end

    // every-cycle model comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            nchk++;
            if (out_valid !== e_vld || out_data !== e_dat) begin
                nbad++;
                $display("FAIL %s model compare: vld=%b data=%h expected vld=%b data=%h",
                         cur_req, out_valid, out_data, e_vld, e_dat);
            end
            nchk++;
            if ($countones(out_valid) > 1) begin
                nbad++;
                $display("FAIL R3 unicast: vld=%b expected at most one bit", out_valid);
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_all_inputs();
        in_valid = 5'b11111;
        for (int p = 0; p < 5; p++) in_data[p*W +: W] = 16'h1000 + 16'(p);
    endtask

    // load at current negedge; returns at the negedge where outputs use it
    task automatic route(input logic [4:0] c);
        route_code = c;
        route_load = 1'b1;
        @(negedge clk);
        route_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk("R6 reset valid", 64'(out_valid), 64'h0);
        chk("R6 reset data", 64'(out_data), 64'h0);
        rst_n = 1'b1;
        set_all_inputs();
        @(negedge clk);
        @(negedge clk);
        chk("R6 idle route after reset", 64'(out_valid), 64'h0);

        // R1: code table
        cur_req = "R1";
        route(5'd7);
        chk("R1 code7 N->W vld", 64'(out_valid), 64'b01000);
        chk("R1 code7 N->W data", 64'(out_data[3*W +: W]), 64'h1001);
        route(5'd14);
        chk("R1 code14 W->N vld", 64'(out_valid), 64'b00010);
        chk("R1 code14 W->N data", 64'(out_data[1*W +: W]), 64'h1003);
        route(5'd20);
        chk("R1 code20 S->W data", 64'(out_data[3*W +: W]), 64'h1004);
        route(5'd1);
        chk("R1 code1 M->N vld", 64'(out_valid), 64'b00010);
        route(5'd10);
        chk("R1 code10 E->N data", 64'(out_data[1*W +: W]), 64'h1002);
        for (int c = 1; c <= 20; c++) route(5'(c));

        // R2: idle codes
        cur_req = "R2";
        route(5'd0);
        chk("R2 code0 idle", 64'(out_valid), 64'h0);
        route(5'd21);
        chk("R2 code21 idle", 64'(out_data), 64'h0);
        route(5'd31);
        chk("R2 code31 idle", 64'(out_valid), 64'h0);

        // R5: timing of load and persistence
        cur_req = "R5";
        route_code = 5'd2;
        route_load = 1'b1;
        @(negedge clk);
        route_load = 1'b0;
        chk("R5 not before next edge", 64'(out_valid), 64'h0);
        @(negedge clk);
        chk("R5 code2 M->E active", 64'(out_valid), 64'b00100);
        route_code = 5'd8;
        @(negedge clk);
        @(negedge clk);
        chk("R5 code bus ignored without load", 64'(out_valid), 64'b00100);

        // R4: valid and data follow one cycle later
        cur_req = "R4";
        in_valid = 5'b11110;
        in_data[0 +: W] = 16'hBEEF;
        @(negedge clk);
        chk("R4 invalid source passes valid 0", 64'(out_valid), 64'h0);
        in_valid = 5'b00001;
        in_data[0 +: W] = 16'h5A5A;
        @(negedge clk);
        chk("R4 data follows", 64'(out_data[2*W +: W]), 64'h5A5A);

        // R7..R9: park buffer on a West->East route
        cur_req = "R7";
        in_valid = '0;
        route(5'd15);
        park_west = 1'b1;
        in_valid = 5'b01000;
        in_data[3*W +: W] = 16'hAAAA;
        @(negedge clk);
        chk("R7 parked word not forwarded", 64'(out_valid), 64'h0);
        cur_req = "R8";
        park_west = 1'b0;
        in_data[3*W +: W] = 16'hBBBB;
        @(negedge clk);
        chk("R8 pass-through while parked", 64'(out_data[2*W +: W]), 64'hBBBB);
        park_west = 1'b1;
        in_data[3*W +: W] = 16'hCCCC;
        @(negedge clk);
        chk("R8 second park dropped", 64'(out_valid), 64'h0);
        cur_req = "R9";
        park_west = 1'b0;
        release_hold = 1'b1;
        in_data[3*W +: W] = 16'hDDDD;
        @(negedge clk);
        release_hold = 1'b0;
        in_data[3*W +: W] = 16'hEEEE;
        @(negedge clk);
        chk("R9 parked word sent", 64'(out_data[2*W +: W]), 64'hAAAA);
        chk("R9 parked word valid", 64'(out_valid), 64'b00100);
        @(negedge clk);
        chk("R9 back to live West", 64'(out_data[2*W +: W]), 64'hEEEE);

        // R10: release while empty
        cur_req = "R10";
        in_valid = '0;
        release_hold = 1'b1;
        @(negedge clk);
        release_hold = 1'b0;
        @(negedge clk);
        chk("R10 release while empty", 64'(out_valid), 64'h0);

        // R6: async reset with a parked word
        cur_req = "R6";
        park_west = 1'b1;
        in_valid = 5'b01000;
        in_data[3*W +: W] = 16'h7777;
        @(negedge clk);
        park_west = 1'b0;
        in_valid = 5'b01000;
        in_data[3*W +: W] = 16'h1234;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 async clear", 64'(out_valid), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = '0;
        route(5'd15);
        release_hold = 1'b1;
        @(negedge clk);
        release_hold = 1'b0;
        @(negedge clk);
        chk("R6 buffer emptied by reset", 64'(out_valid), 64'h0);

        // random traffic against the model
        cur_req = "R4";
        for (int n = 0; n < 600; n++) begin
            route_code   = 5'($urandom_range(0, 31));
            route_load   = ($urandom_range(0, 3) == 0);
            park_west    = ($urandom_range(0, 3) == 0);
            release_hold = ($urandom_range(0, 3) == 0);
            in_valid     = 5'($urandom);
            for (int p = 0; p < 5; p++) in_data[p*W +: W] = 16'($urandom);
            @(negedge clk);
        end
        route_load = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule